// File: doc/BRIEF.md
# Multichannel ADC Frame Burst Packer

The packer captures one simultaneous 16-bit sample from each of sixteen converter channels whenever the sample strobe is high. It treats that set of samples as one 32-byte frame. Each frame waits in a small frame queue. It is then sent to external memory as a single write burst of eight 32-bit beats.

Frames land in a circular region of memory. Every burst starts on a frame boundary. The slot index moves forward one whole frame at a time and wraps back to the region base after the last slot.

A write-pointer output tells downstream readers where the next frame will go. Frames below that pointer are complete. When the memory side falls behind and the queue fills, further frames are discarded and a sticky overflow flag records the loss. A clear input resets the flag.

Top module: `adc_frame_packer`

## Requirements
- R1: Each strobe cycle that is accepted produces exactly one burst of eight beats. Bursts go out in the order the frames arrived, and no other beats appear.
- R2: Channel c occupies `smp_data` bits 16c+15:16c. Beat k (k = 0..7) carries channel 2k in bits 15:0 and channel 2k+1 in bits 31:16.
- R3: `wr_last` is high on beat 7 of a burst and on no other beat. It is never high while `wr_valid` is low.
- R4: A beat is consumed only on a cycle where `wr_valid` and `wr_ready` are both high. While `wr_ready` is low, `wr_valid`, `wr_data` and `wr_addr` hold their values.
- R5: Every burst address equals BASE_ADDR + 32 × slot, so its low 5 bits are zero.
- R6: Successive bursts use slots 0, 1, …, BUF_FRAMES−1 and then return to slot 0, which is the base address.
- R7: `wr_ptr` shows BASE_ADDR + 32 × (the slot of the next burst). It changes only in the cycle after the last beat of a burst is accepted. During a burst it equals that burst's address.
- R8: The queue holds 4 frames, and one more frame can be in transmission. While the write side is stalled, back-to-back frames beyond those five are dropped. Each dropped frame sets `ovf_flag`, and the flag stays high until it is cleared.
- R9: `ovf_clear` resets `ovf_flag` on the next clock edge. If a drop happens in the same cycle as a clear, the flag stays set.
- R10: While synchronous reset `rst` is high, and right after it, `wr_valid` and `wr_last` are 0, `ovf_flag` is 0, `wr_ptr` equals BASE_ADDR and the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | One cycle per simultaneous sample set |
| smp_data | input | 256 | Sixteen 16-bit samples, channel c at bits 16c+15:16c |
| ovf_clear | input | 1 | Clears the overflow flag |
| wr_addr | output | ADDR_W | Frame-aligned start address of the current burst |
| wr_valid | output | 1 | Beat valid |
| wr_data | output | 32 | Beat data |
| wr_last | output | 1 | Final beat of the burst |
| wr_ready | input | 1 | Memory side accepts the beat |
| wr_ptr | output | ADDR_W | Address of the next slot to be written |
| ovf_flag | output | 1 | Sticky flag set when a frame is dropped |

## Verification
Frames use sample values that encode both the channel and the frame number. Because of this, a swapped half-word, a shifted beat or a reordered frame shows up as a data mismatch.

Several input patterns are used:
- Widely spaced frames with the write side always ready confirm the basic packing and the pointer movement.
- Randomly gated `wr_ready` exposes any beat that is consumed without a handshake, or data that changes during a stall.
- Back-to-back frames show that the queue keeps its order when it holds more than one frame.
- A fully stalled write side with six consecutive frames separates the five frames that must survive from the one that must be dropped. A repeat of that run with the clear input held high shows that a drop outranks a clear.

// File: rtl/adcpk_pkg.sv
package adcpk_pkg;

    localparam int NUM_CH       = 16;
    localparam int SAMPLE_W     = 16;
    localparam int BEAT_W       = 32;
    localparam int SMP_PER_BEAT = BEAT_W / SAMPLE_W;
    localparam int BEATS        = NUM_CH / SMP_PER_BEAT;
    localparam int BEAT_IDX_W   = $clog2(BEATS);
    localparam int FRAME_BYTES  = NUM_CH * SAMPLE_W / 8;
    localparam int FRAME_SHIFT  = $clog2(FRAME_BYTES);

    typedef logic [SAMPLE_W-1:0]  sample_t;
    typedef sample_t [NUM_CH-1:0] frame_t;
    typedef logic [BEAT_W-1:0]    beat_t;

    typedef enum logic {
        WR_IDLE  = 1'b0,
        WR_BURST = 1'b1
    } wr_state_e;

    // Lower channel of the pair goes in the low half of the beat.
    function automatic beat_t pick_beat(frame_t f, logic [BEAT_IDX_W-1:0] k);
        beat_t b;
        for (int j = 0; j < SMP_PER_BEAT; j++) begin
            b[j*SAMPLE_W +: SAMPLE_W] = f[int'(k) * SMP_PER_BEAT + j];
        end
        return b;
    endfunction

endpackage

// File: rtl/frame_fifo.sv
module frame_fifo
    import adcpk_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   push,
    input  frame_t din,
    input  logic   pop,
    input  logic   ovf_clear,
    output frame_t dout,
    output logic   empty,
    output logic   ovf
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;

    frame_t             mem [DEPTH];
    logic [PTR_W-1:0]   wptr, rptr;
    logic [CNT_W-1:0]   count;
    logic               full, accept, drop;

    assign full   = (count == CNT_W'(DEPTH));
    assign empty  = (count == '0);
    assign accept = push && !full;
    assign drop   = push && full;
    assign dout   = mem[rptr];

    always_ff @(posedge clk) begin
        if (accept) mem[wptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
            ovf   <= 1'b0;
        end else begin
            if (accept) wptr <= wptr + 1'b1;
            if (pop)    rptr <= rptr + 1'b1;
            count <= count + CNT_W'(accept) - CNT_W'(pop);
            if (drop)           ovf <= 1'b1;
            else if (ovf_clear) ovf <= 1'b0;
        end
    end

    // R8
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));
    // R8
    drop_sets_ovf_chk: assert property (@(posedge clk) disable iff (rst)
        drop |=> ovf);
    // R1
    no_pop_empty_chk: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);

endmodule

// File: rtl/ring_pointer.sv
module ring_pointer
    import adcpk_pkg::*;
#(
    parameter int              ADDR_W     = 32,
    parameter int              BUF_FRAMES = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              advance,
    output logic [ADDR_W-1:0] ptr_addr
);
    localparam int SLOT_W = $clog2(BUF_FRAMES);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(BUF_FRAMES - 1);

    logic [SLOT_W-1:0] slot;

    assign ptr_addr = BASE_ADDR + (ADDR_W'(slot) << FRAME_SHIFT);

    always_ff @(posedge clk) begin
        if (rst)          slot <= '0;
        else if (advance) slot <= (slot == LAST_SLOT) ? '0 : slot + 1'b1;
    end

    // R7
    ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !advance |=> $stable(ptr_addr));
    // R6
    ptr_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (advance && slot == LAST_SLOT) |=> ptr_addr == BASE_ADDR);

endmodule

// File: rtl/burst_writer.sv
module burst_writer
    import adcpk_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fifo_empty,
    input  frame_t            fifo_dout,
    output logic              fifo_pop,
    input  logic [ADDR_W-1:0] slot_addr,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              wr_valid,
    output beat_t             wr_data,
    output logic              wr_last,
    input  logic              wr_ready,
    output logic              frame_done
);
    wr_state_e             state;
    logic [BEAT_IDX_W-1:0] beat;
    frame_t                hold;
    logic                  take;

    assign fifo_pop   = (state == WR_IDLE) && !fifo_empty;
    assign wr_valid   = (state == WR_BURST);
    assign wr_data    = pick_beat(hold, beat);
    assign wr_last    = wr_valid && (beat == BEAT_IDX_W'(BEATS - 1));
    assign wr_addr    = slot_addr;
    assign take       = wr_valid && wr_ready;
    assign frame_done = take && wr_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= WR_IDLE;
            beat  <= '0;
            hold  <= '0;
        end else begin
            unique case (state)
                WR_IDLE: if (fifo_pop) begin
                    hold  <= fifo_dout;
                    beat  <= '0;
                    state <= WR_BURST;
                end
                WR_BURST: if (take) begin
                    if (wr_last) state <= WR_IDLE;
                    else         beat  <= beat + 1'b1;
                end
                default: state <= WR_IDLE;
            endcase
        end
    end

    // R4
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data) && $stable(wr_addr)));
    // R3
    last_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        wr_last |-> wr_valid);

endmodule

// File: rtl/adc_frame_packer.sv
module adc_frame_packer
    import adcpk_pkg::*;
#(
    parameter int                ADDR_W     = 32,
    parameter int                BUF_FRAMES = 16,
    parameter int                FIFO_DEPTH = 4,
    parameter logic [ADDR_W-1:0] BASE_ADDR  = '0
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       smp_valid,
    input  logic [NUM_CH*SAMPLE_W-1:0] smp_data,
    input  logic                       ovf_clear,
    output logic [ADDR_W-1:0]          wr_addr,
    output logic                       wr_valid,
    output logic [BEAT_W-1:0]          wr_data,
    output logic                       wr_last,
    input  logic                       wr_ready,
    output logic [ADDR_W-1:0]          wr_ptr,
    output logic                       ovf_flag
);
    frame_t q_dout;
    logic   q_empty, q_pop, done;

    frame_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (smp_valid),
        .din       (frame_t'(smp_data)),
        .pop       (q_pop),
        .ovf_clear (ovf_clear),
        .dout      (q_dout),
        .empty     (q_empty),
        .ovf       (ovf_flag)
    );

    ring_pointer #(
        .ADDR_W     (ADDR_W),
        .BUF_FRAMES (BUF_FRAMES),
        .BASE_ADDR  (BASE_ADDR)
    ) u_ptr (
        .clk      (clk),
        .rst      (rst),
        .advance  (done),
        .ptr_addr (wr_ptr)
    );

    burst_writer #(.ADDR_W(ADDR_W)) u_wr (
        .clk        (clk),
        .rst        (rst),
        .fifo_empty (q_empty),
        .fifo_dout  (q_dout),
        .fifo_pop   (q_pop),
        .slot_addr  (wr_ptr),
        .wr_addr    (wr_addr),
        .wr_valid   (wr_valid),
        .wr_data    (wr_data),
        .wr_last    (wr_last),
        .wr_ready   (wr_ready),
        .frame_done (done)
    );

    // R5
    addr_align_chk: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> (wr_addr[FRAME_SHIFT-1:0] == '0));
    // R9
    ovf_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (ovf_clear && !smp_valid) |=> !ovf_flag);

endmodule

// File: tb/test_adc_frame_packer.sv
module test_adc_frame_packer;
    import adcpk_pkg::*;

    localparam int          AW    = 32;
    localparam int          NFR   = 4;
    localparam logic [31:0] BASE  = 32'h0000_1000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic smp_valid = 1'b0;
    logic [NUM_CH*SAMPLE_W-1:0] smp_data = '0;
    logic ovf_clear = 1'b0;
    logic wr_ready = 1'b0;
    logic [AW-1:0] wr_addr, wr_ptr;
    logic wr_valid, wr_last, ovf_flag;
    logic [BEAT_W-1:0] wr_data;

    int total = 0;
    int bad = 0;
    int ready_mode = 1;       // 0 low, 1 high, 2 random
    logic [31:0] exp_q[$];
    int slot = 0;
    int beat_i = 0;

    always #2 clk = ~clk;

    adc_frame_packer #(
        .ADDR_W(AW), .BUF_FRAMES(NFR), .FIFO_DEPTH(4), .BASE_ADDR(BASE)
    ) i_adc_frame_packer (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
        .ovf_clear(ovf_clear), .wr_addr(wr_addr), .wr_valid(wr_valid),
        .wr_data(wr_data), .wr_last(wr_last), .wr_ready(wr_ready),
        .wr_ptr(wr_ptr), .ovf_flag(ovf_flag)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // Driver: one frame per call; caller stands just after a rising edge.
    task automatic send_frame(input int id, input bit kept);
        logic [15:0] s [NUM_CH];
        for (int c = 0; c < NUM_CH; c++) begin
            s[c] = {id[7:0], 4'hA ^ id[11:8], c[3:0]};
            smp_data[16*c +: 16] = s[c];
        end
        smp_valid = 1'b1;
        if (kept) begin
            for (int k = 0; k < 8; k++) exp_q.push_back({s[2*k+1], s[2*k]});
        end
        @(posedge clk); #1;
        smp_valid = 1'b0;
    endtask

    task automatic wait_drain();
        for (int i = 0; i < 2000 && exp_q.size() != 0; i++) @(posedge clk);
        repeat (4) @(posedge clk);
        #1;
        chk(exp_q.size() == 0, "R1 drain", exp_q.size(), 0);
    endtask

    // Ready driver
    initial begin
        logic [7:0] lf = 8'h5B;
        forever begin
            @(posedge clk); #1;
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            wr_ready = (ready_mode == 1) ? 1'b1 :
                       (ready_mode == 2) ? (lf[0] | lf[1]) : 1'b0;
        end
    end

    // Monitor / scoreboard
    initial begin
        bit ptr_pend = 0;
        bit stalled = 0;
        logic [31:0] pd, pa;
        forever begin
            @(negedge clk);
            if (rst) begin
                ptr_pend = 0; stalled = 0;
            end else begin
                if (ptr_pend) begin
                    chk(wr_ptr == BASE + 32'(slot * 32), "R7 ptr after last", wr_ptr, BASE + 32'(slot * 32));
                    ptr_pend = 0;
                end
                if (stalled) begin
                    chk(wr_valid && wr_data == pd && wr_addr == pa, "R4 stall hold", wr_data, pd);
                end
                stalled = wr_valid && !wr_ready;
                pd = wr_data; pa = wr_addr;
                if (!wr_valid) chk(!wr_last, "R3 last without valid", wr_last, 0);
                if (wr_valid && wr_ready) begin
                    if (exp_q.size() == 0) begin
                        chk(0, "R1 unexpected beat", wr_data, 0);
                    end else begin
                        logic [31:0] e;
                        e = exp_q.pop_front();
                        chk(wr_data == e, "R2 beat data", wr_data, e);
                        chk(wr_last == (beat_i == 7), "R3 last flag", wr_last, beat_i == 7);
                        chk(wr_addr == BASE + 32'(slot * 32) && wr_addr[4:0] == 0, "R5 R6 address", wr_addr, BASE + 32'(slot * 32));
                        chk(wr_ptr == wr_addr, "R7 ptr during burst", wr_ptr, wr_addr);
                        if (beat_i == 7) begin
                            beat_i = 0;
                            slot = (slot + 1) % NFR;
                            ptr_pend = 1;
                        end else beat_i++;
                    end
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog act=hung exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R10
        chk(!wr_valid && !wr_last, "R10 reset valid", wr_valid, 0);
        chk(wr_ptr == BASE, "R10 reset ptr", wr_ptr, BASE);
        chk(!ovf_flag, "R10 reset ovf", ovf_flag, 0);
        rst = 1'b0;
        @(posedge clk); #1;
        chk(!wr_valid && wr_ptr == BASE && !ovf_flag, "R10 after reset", wr_valid, 0);

        // Pattern A: spaced frames, always ready
        ready_mode = 1;
        for (int f = 0; f < 3; f++) begin
            send_frame(f + 1, 1);
            repeat (14) @(posedge clk);
            #1;
        end
        wait_drain();

        // Pattern B: random ready, crosses the wrap (R6)
        ready_mode = 2;
        for (int f = 0; f < 6; f++) begin
            send_frame(f + 16, 1);
            repeat (40) @(posedge clk);
            #1;
        end
        wait_drain();

        // Pattern C: back-to-back frames
        ready_mode = 1;
        @(posedge clk); #1;
        for (int f = 0; f < 3; f++) send_frame(f + 32, 1);
        wait_drain();

        // Pattern D: stalled, six back-to-back frames, sixth dropped (R8)
        ready_mode = 0;
        repeat (2) @(posedge clk);
        #1;
        for (int f = 0; f < 6; f++) send_frame(f + 48, f < 5);
        chk(ovf_flag, "R8 ovf set", ovf_flag, 1);
        chk(wr_valid && wr_ptr == BASE + 32'(slot * 32), "R7 ptr frozen in stall", wr_ptr, BASE + 32'(slot * 32));
        ready_mode = 1;
        wait_drain();
        chk(ovf_flag, "R8 ovf sticky", ovf_flag, 1);
        ovf_clear = 1'b1;
        @(posedge clk); #1;
        ovf_clear = 1'b0;
        chk(!ovf_flag, "R9 clear", ovf_flag, 0);

        // Drop and clear in the same cycle: set wins (R9)
        ready_mode = 0;
        repeat (2) @(posedge clk);
        #1;
        for (int f = 0; f < 6; f++) begin
            ovf_clear = (f == 5);
            send_frame(f + 64, f < 5);
        end
        ovf_clear = 1'b0;
        chk(ovf_flag, "R9 drop beats clear", ovf_flag, 1);
        ready_mode = 2;
        wait_drain();
        ovf_clear = 1'b1;
        @(posedge clk); #1;
        ovf_clear = 1'b0;
        chk(!ovf_flag, "R9 clear again", ovf_flag, 0);
        chk(wr_ptr == BASE + 32'(slot * 32), "R6 final slot", wr_ptr, BASE + 32'(slot * 32));

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule